// File: doc/BRIEF.md
# Stacked and Rotating Register Rename

This block turns architectural register numbers into physical register numbers for one register file, using only arithmetic and no free list. Registers below a global boundary always map to themselves. Registers above that boundary form an upper region. In the integer file, this region is a per-function stacked frame: its physical position is set by a frame base that grows on each call and is put back on each return. The lowest part of the upper region can also rotate. A loop-branch event steps a rotating base, so each iteration of a software-pipelined loop reaches different physical registers through the same architectural names.

Each lookup lane takes an index and returns a physical index. By default there are three lanes, and all of them use the same mapping state. The same module serves the floating-point and predicate files with the stacking switched off. In that form the whole upper region rotates and the frame plays no part. A return restores a saved frame base that the surrounding logic supplies. That restored base already applies to lookups in the cycle of the return.

Top module: `stack_rot_rename`

## Requirements
- R1: An index below GLOBAL_REGS (32 for the integer and floating-point files, 16 for predicates) maps to the same number on every lane.
- R2: With stacking on, an upper index whose offset o = index − GLOBAL_REGS lies outside the rotating part maps to GLOBAL_REGS + ((o + frameBase) mod POOL_REGS). The result is always below GLOBAL_REGS + POOL_REGS.
- R3: A call (callEn=1, retEn=0) sets frameBase to (frameBase + callSize) mod POOL_REGS from the next cycle on. Lookups in the call cycle still use the old base.
- R4: A return (retEn=1) makes retBase the frame base for lookups in that same cycle and in later cycles. When a return and a call happen in the same cycle, the return wins.
- R5: With stacking on and rs = min(rotSize, UPPER), an offset o < rs first becomes (o + rotBase) mod rs. The stacked mapping of R2 is then applied to it.
- R6: Each rotate event (rotEn=1) changes rotBase to rotBase − 1 from the next cycle on. When rotBase is 0 or at least rs, it becomes rs − 1 instead. When rs = 0, rotBase stays 0.
- R7: With stacking off, the rotating part is the whole upper region, of size UPPER = ARCH_REGS − GLOBAL_REGS. The result is GLOBAL_REGS + ((o + rotBase) mod UPPER), and rotSize, calls and returns have no effect on it.
- R8: All lanes are looked up in the same cycle against the same frame base and rotating base. Each lane's result depends only on its own index.
- R9: After reset, frameBase and rotBase are 0, so every index maps to itself until the first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| callEn | input | 1 | Call event: advance the frame base |
| callSize | input | SIZE_W (7) | Size of the caller's local region |
| retEn | input | 1 | Return event: restore the frame base |
| retBase | input | FB_W (7) | Saved frame base restored on return |
| rotEn | input | 1 | Loop-rotate event |
| rotSize | input | SIZE_W (7) | Size of the rotating part (used when stacking is on) |
| lookupIdx | input | NUM_LANES*IDX_W (21) | Architectural indices; lane k sits at bits k*IDX_W upward |
| physIdx | output | NUM_LANES*PHYS_W (24) | Physical indices; lane k sits at bits k*PHYS_W upward |

## Verification
The bench builds two instances. The first uses the default integer configuration: 128 registers, 32 globals, stacking on and a 128-entry pool. It reaches frame wrap-around at the pool end, a return and a call in the same cycle, and a full cycle of 16 rotations over a partial rotating region. The second uses the predicate configuration: 64 registers, 16 globals and stacking off. It shows the whole 48-entry upper region rotating while rotSize, calls and returns are driven on it and have no effect.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef struct packed {
    logic retLoad;
    logic callAdv;
    logic rotStep;
  } mapStrobes_t;
endpackage

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
(
  input  logic        callEn,
  input  logic        retEn,
  input  logic        rotEn,
  output mapStrobes_t strobes
);
  always_comb begin
    strobes.retLoad = retEn;
    strobes.callAdv = callEn & ~retEn;
    strobes.rotStep = rotEn;
  end
endmodule

// File: rtl/srr_map.sv
module srr_map
  import srr_pkg::*;
#(
  parameter int ARCH_REGS   = 128,
  parameter int GLOBAL_REGS = 32,
  parameter int POOL_REGS   = 128,
  parameter bit STACKED     = 1'b1,
  parameter int NUM_LANES   = 3,
  parameter int IDX_W       = 7,
  parameter int SIZE_W      = 7,
  parameter int FB_W        = 7,
  parameter int PHYS_W      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mapStrobes_t                 strobes,
  input  logic [SIZE_W-1:0]           callSize,
  input  logic [FB_W-1:0]             retBase,
  input  logic [SIZE_W-1:0]           rotSize,
  input  logic [NUM_LANES*IDX_W-1:0]  lookupIdx,
  output logic [NUM_LANES*PHYS_W-1:0] physIdx,
  output logic [FB_W-1:0]             curFrame,
  output logic [SIZE_W-1:0]           curRot
);
  localparam int UPPER = ARCH_REGS - GLOBAL_REGS;

  logic [FB_W-1:0]   frameQ, frameNext, frameEff;
  logic [SIZE_W-1:0] rotQ, rotNext;
  int                rotSpan;

  // rotating span: requested size clamped to the upper region, or all of it
  always_comb begin
    if (STACKED) rotSpan = (int'(rotSize) > UPPER) ? UPPER : int'(rotSize);
    else         rotSpan = UPPER;
  end

  // a return takes effect on the lookups of its own cycle
  assign frameEff = strobes.retLoad ? retBase : frameQ;

  always_comb begin
    int sum;
    sum = int'(frameQ) + int'(callSize);
    if (sum >= POOL_REGS) sum = sum - POOL_REGS;
    if (strobes.retLoad)      frameNext = retBase;
    else if (strobes.callAdv) frameNext = FB_W'(sum);
    else                      frameNext = frameQ;
  end

  always_comb begin
    rotNext = rotQ;
    if (strobes.rotStep) begin
      if (rotSpan == 0)                          rotNext = '0;
      else if (rotQ == '0 || int'(rotQ) >= rotSpan) rotNext = SIZE_W'(rotSpan - 1);
      else                                       rotNext = rotQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
      rotQ   <= '0;
    end else begin
      frameQ <= frameNext;
      rotQ   <= rotNext;
    end
  end

  assign curFrame = frameQ;
  assign curRot   = rotQ;

  function automatic logic [PHYS_W-1:0] mapOne(input int idx, input int fb,
                                               input int rb, input int rs);
    int off;
    int tmp;
    if (idx < GLOBAL_REGS) return PHYS_W'(idx);
    off = idx - GLOBAL_REGS;
    if (off < rs) begin
      tmp = off + rb;
      if (tmp >= rs) tmp = tmp - rs;
      off = tmp;
    end
    if (STACKED) begin
      tmp = off + fb;
      if (tmp >= POOL_REGS) tmp = tmp - POOL_REGS;
      return PHYS_W'(GLOBAL_REGS + tmp);
    end
    return PHYS_W'(GLOBAL_REGS + off);
  endfunction

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    always_comb begin
      physIdx[l*PHYS_W +: PHYS_W] = mapOne(int'(lookupIdx[l*IDX_W +: IDX_W]),
                                           int'(frameEff), int'(rotQ), rotSpan);
    end
  end
endmodule

// File: rtl/stack_rot_rename.sv
module stack_rot_rename
  import srr_pkg::*;
#(
  parameter  int ARCH_REGS   = 128,
  parameter  int GLOBAL_REGS = 32,
  parameter  int POOL_REGS   = 128,
  parameter  bit STACKED     = 1'b1,
  parameter  int NUM_LANES   = 3,
  localparam int IDX_W  = $clog2(ARCH_REGS),
  localparam int SIZE_W = $clog2(ARCH_REGS - GLOBAL_REGS + 1),
  localparam int FB_W   = $clog2(POOL_REGS),
  localparam int PHYS_W = STACKED ? $clog2(GLOBAL_REGS + POOL_REGS) : IDX_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        callEn,
  input  logic [SIZE_W-1:0]           callSize,
  input  logic                        retEn,
  input  logic [FB_W-1:0]             retBase,
  input  logic                        rotEn,
  input  logic [SIZE_W-1:0]           rotSize,
  input  logic [NUM_LANES*IDX_W-1:0]  lookupIdx,
  output logic [NUM_LANES*PHYS_W-1:0] physIdx
);
  mapStrobes_t       strobes;
  logic [FB_W-1:0]   curFrame;
  logic [SIZE_W-1:0] curRot;

  srr_ctrl u_ctrl (
    .callEn (callEn),
    .retEn  (retEn),
    .rotEn  (rotEn),
    .strobes(strobes)
  );

  srr_map #(
    .ARCH_REGS(ARCH_REGS), .GLOBAL_REGS(GLOBAL_REGS), .POOL_REGS(POOL_REGS),
    .STACKED(STACKED), .NUM_LANES(NUM_LANES), .IDX_W(IDX_W), .SIZE_W(SIZE_W),
    .FB_W(FB_W), .PHYS_W(PHYS_W)
  ) u_map (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .callSize (callSize),
    .retBase  (retBase),
    .rotSize  (rotSize),
    .lookupIdx(lookupIdx),
    .physIdx  (physIdx),
    .curFrame (curFrame),
    .curRot   (curRot)
  );
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int ARCH_REGS   = 128,
  parameter int GLOBAL_REGS = 32,
  parameter int POOL_REGS   = 128,
  parameter bit STACKED     = 1'b1,
  parameter int NUM_LANES   = 3,
  parameter int IDX_W       = 7,
  parameter int SIZE_W      = 7,
  parameter int FB_W        = 7,
  parameter int PHYS_W      = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        callEn,
  input logic [SIZE_W-1:0]           callSize,
  input logic                        retEn,
  input logic [FB_W-1:0]             retBase,
  input logic                        rotEn,
  input logic [SIZE_W-1:0]           rotSize,
  input logic [NUM_LANES*IDX_W-1:0]  lookupIdx,
  input logic [NUM_LANES*PHYS_W-1:0] physIdx,
  input logic [FB_W-1:0]             curFrame,
  input logic [SIZE_W-1:0]           curRot
);
  localparam int UPPER = ARCH_REGS - GLOBAL_REGS;
  int span;
  always_comb begin
    if (STACKED) span = (int'(rotSize) > UPPER) ? UPPER : int'(rotSize);
    else         span = UPPER;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : gChk
    assert_global_identity_R1: assert property (@(posedge clk) disable iff (!rstN)
      int'(lookupIdx[l*IDX_W +: IDX_W]) < GLOBAL_REGS
        |-> int'(physIdx[l*PHYS_W +: PHYS_W]) == int'(lookupIdx[l*IDX_W +: IDX_W]));
    assert_phys_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
      STACKED |-> int'(physIdx[l*PHYS_W +: PHYS_W]) < GLOBAL_REGS + POOL_REGS);
  end

  assert_call_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && !retEn) |=>
      int'(curFrame) == (int'($past(curFrame)) + int'($past(callSize))) % POOL_REGS);

  assert_return_restore_R4: assert property (@(posedge clk) disable iff (!rstN)
    retEn |=> curFrame == $past(retBase));

  assert_rotate_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rotEn && curRot != '0 && int'(curRot) < span) |=> curRot == $past(curRot) - 1'b1);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!callEn && !retEn && !rotEn) |=> ($stable(curFrame) && $stable(curRot)));
endmodule

bind stack_rot_rename srr_checker #(
  .ARCH_REGS(ARCH_REGS), .GLOBAL_REGS(GLOBAL_REGS), .POOL_REGS(POOL_REGS),
  .STACKED(STACKED), .NUM_LANES(NUM_LANES), .IDX_W(IDX_W), .SIZE_W(SIZE_W),
  .FB_W(FB_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .callEn(callEn), .callSize(callSize), .retEn(retEn),
  .retBase(retBase), .rotEn(rotEn), .rotSize(rotSize), .lookupIdx(lookupIdx),
  .physIdx(physIdx), .curFrame(curFrame), .curRot(curRot)
);

// File: tb/test_stack_rot_rename.sv
`timescale 1ns/1ps
module test_stack_rot_rename;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        callEn = 0, retEn = 0, rotEn = 0, pRotEn = 0;
  logic [6:0]  callSize = '0, retBase = '0, rotSize = '0;
  logic [20:0] lookupIdx = '0;
  logic [17:0] pIdx = '0;
  logic [23:0] physIdx;
  logic [17:0] pPhys;

  stack_rot_rename i_stack_rot_rename (
    .clk(clk), .rstN(rstN), .callEn(callEn), .callSize(callSize), .retEn(retEn),
    .retBase(retBase), .rotEn(rotEn), .rotSize(rotSize), .lookupIdx(lookupIdx),
    .physIdx(physIdx)
  );

  stack_rot_rename #(.ARCH_REGS(64), .GLOBAL_REGS(16), .STACKED(1'b0)) i_stack_rot_renamePred (
    .clk(clk), .rstN(rstN), .callEn(callEn), .callSize(callSize[5:0]), .retEn(retEn),
    .retBase(retBase), .rotEn(pRotEn), .rotSize(rotSize[5:0]), .lookupIdx(pIdx),
    .physIdx(pPhys)
  );

  typedef struct { bit pred; int lane; int exp; string tag; } expItem_t;
  expItem_t scb[$];
  int nChecks = 0, nFail = 0;

  // staged stimulus
  bit sCall, sRet, sRot, sPRot;
  int sCallSize, sRetBase, sRotSize;
  int sIdx[3], sPIdx[3];
  // reference state
  int mFb = 0, mRb = 0, mPRb = 0;

  function automatic int refInt(int idx, int fb, int rb, int rs);
    int o;
    if (idx < 32) return idx;
    o = idx - 32;
    if (o < rs) o = (o + rb) % rs;
    return 32 + (o + fb) % 128;
  endfunction

  function automatic int refPred(int idx, int rb);
    if (idx < 16) return idx;
    return 16 + (idx - 16 + rb) % 48;
  endfunction

  task automatic go(string tag);
    int fbNow, rs;
    expItem_t it;
    @(posedge clk); #1;
    callEn = sCall; retEn = sRet; rotEn = sRot; pRotEn = sPRot;
    callSize = 7'(sCallSize); retBase = 7'(sRetBase); rotSize = 7'(sRotSize);
    for (int l = 0; l < 3; l++) begin
      lookupIdx[l*7 +: 7] = 7'(sIdx[l]);
      pIdx[l*6 +: 6] = 6'(sPIdx[l]);
    end
    rs = (sRotSize > 96) ? 96 : sRotSize;
    fbNow = sRet ? sRetBase : mFb;
    for (int l = 0; l < 3; l++) begin
      it.pred = 0; it.lane = l; it.exp = refInt(sIdx[l], fbNow, mRb, rs); it.tag = tag;
      scb.push_back(it);
      it.pred = 1; it.exp = refPred(sPIdx[l], mPRb); it.tag = {"R7 ", tag};
      scb.push_back(it);
    end
    if (sRet) mFb = sRetBase;
    else if (sCall) mFb = (mFb + sCallSize) % 128;
    if (sRot) begin
      if (rs == 0) mRb = 0;
      else if (mRb == 0 || mRb >= rs) mRb = rs - 1;
      else mRb = mRb - 1;
    end
    if (sPRot) mPRb = (mPRb == 0) ? 47 : mPRb - 1;
  endtask

  always @(negedge clk) begin
    while (scb.size() > 0) begin
      expItem_t it;
      int act;
      it = scb.pop_front();
      act = it.pred ? int'(pPhys[it.lane*6 +: 6]) : int'(physIdx[it.lane*8 +: 8]);
      nChecks++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s %s lane %0d: actual %0d expected %0d", it.tag,
                 it.pred ? "pred" : "int", it.lane, act, it.exp);
      end
    end
  end

  bit finished = 0;
  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    sCall = 0; sRet = 0; sRot = 0; sPRot = 0;
    sCallSize = 0; sRetBase = 0; sRotSize = 0;
    sIdx = '{0, 31, 32}; sPIdx = '{0, 15, 16};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    go("R9 R1");                                  // identity after reset
    sIdx = '{5, 40, 127}; sPIdx = '{16, 40, 63};
    sCall = 1; sCallSize = 20; sPRot = 1;
    go("R3 old base in call cycle");
    sCall = 0;
    go("R3 advanced base");
    sCall = 1; sCallSize = 100;
    go("R3");
    sCall = 0; sPRot = 0;
    go("R2 pool wrap");                           // base 120, 127 -> 119
    sRet = 1; sRetBase = 20; sRotSize = 9;        // rotSize ignored by pred
    go("R4 same-cycle restore");
    sCall = 1; sCallSize = 9; sRetBase = 5;
    go("R4 return beats call");
    sRet = 0; sCall = 0; sRotSize = 0;
    go("R4 priority result");
    sRotSize = 16; sRot = 1; sIdx = '{32, 47, 48};
    go("R5 R8 before first rotate");
    sRot = 0;
    go("R5 R8 after rotate");
    sRot = 1;
    for (int k = 0; k < 15; k++) go("R6 rotate cycle");
    sRot = 0;
    go("R6 back to zero");
    sRotSize = 0; sRot = 1; sIdx = '{33, 60, 100};
    go("R6 empty span");
    sRot = 0;
    go("R6 stays zero");
    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule